// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Wrong-Path Flush

This block settles a branch-if-equal in the decode stage of a five-stage pipeline. The fetch side always assumes not taken and keeps stepping the program counter by one instruction word. Decode presents the branch flag, the two operand values it has just read, the incremented PC that came with the branch, and the 16-bit immediate. A dedicated equality comparator, separate from the execute ALU, makes the decision in that same cycle.

When the branch is taken, the target is the incremented PC plus the sign-extended immediate times four. On the same clock edge, the program counter loads that target and the fetch/decode register is overwritten with an all-zero no-op. That no-op is marked not valid, so later stages cannot use it to write a register or memory. A taken branch therefore costs one bubble. A branch that is not taken costs nothing.

The block owns the program counter and the fetch/decode register. A stall hold from elsewhere in the pipeline freezes both of them, except when a flush is asserted in the same cycle.

Top module: `brfl_top`

## Requirements
- R1: Synchronous active-high reset sets the PC to RESET_PC (default 0), clears the fetch/decode instruction and incremented PC to zero, and clears its valid flag.
- R2: With no hold and no flush, each clock edge advances the PC by 4. On the same edge, the fetch/decode register captures the fetched word and the old PC plus 4, with valid set.
- R3: When the branch flag is high, flush_o and pc_sel_o (1 = branch target, 0 = sequential) are high in the same cycle if and only if the two operands are bitwise equal, whichever bit differs.
- R4: pc_target_o equals id_pc_inc_i plus the 16-bit immediate sign-extended and shifted left by 2, modulo 2^32, in the same cycle. This holds for positive and negative immediates.
- R5: A branch with unequal operands causes no flush and costs no cycle. The PC advances by 4 and the next fetched word becomes valid in the fetch/decode register.
- R6: On a taken branch, the PC loads the target on the same edge that the fetch/decode register becomes the all-zero no-op with valid cleared. On the edge after that, sequential fetch resumes from the target.
- R7: While hold is high and no flush is asserted, the PC and the whole fetch/decode register keep their values.
- R8: When hold and a flush are asserted together, the flush wins. The fetch/decode register is zeroed and invalidated, and the PC loads the target.
- R9: Equal operands with the branch flag low produce no flush and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Stall hold for PC and fetch/decode register |
| fetch_instr_i | input | 32 | Instruction word fetched at pc_o |
| id_branch_i | input | 1 | Decode holds a branch-if-equal |
| id_opa_i | input | 32 | First source operand read in decode |
| id_opb_i | input | 32 | Second source operand read in decode |
| id_pc_inc_i | input | 32 | Incremented PC of the branch in decode |
| id_imm_i | input | 16 | Branch immediate, in words |
| pc_o | output | 32 | Current fetch address |
| pc_sel_o | output | 1 | Next-PC select: 1 = branch target |
| pc_target_o | output | 32 | Computed branch target |
| flush_o | output | 1 | Flush strobe for the fetch/decode register |
| ifid_instr_o | output | 32 | Fetch/decode register instruction |
| ifid_pc_inc_o | output | 32 | Fetch/decode register incremented PC |
| ifid_valid_o | output | 1 | Fetch/decode register holds a real instruction |

## Verification
The decision outputs pc_sel_o, flush_o and pc_target_o are combinational, so they are due in the same cycle as the decode inputs. The bench drives those inputs just after a falling edge and checks the decision outputs a few nanoseconds later, before the next rising edge. The PC and the fetch/decode register have exactly one register stage between the decision and the output, so their effect is due at the first rising edge. The bench samples them one nanosecond after that edge, comparing against the PC and fetched word it recorded before the edge.

// File: rtl/brfl_pkg.sv
package brfl_pkg;
  // Source for the next program counter
  typedef enum logic {
    PC_SEQ = 1'b0,
    PC_BR  = 1'b1
  } pcsel_e;

  // Update mode for the fetch/decode register
  typedef enum logic [1:0] {
    IFID_LOAD = 2'd0,
    IFID_HOLD = 2'd1,
    IFID_ZERO = 2'd2
  } ifid_op_e;
endpackage

// File: rtl/brfl_eq.sv
module brfl_eq #(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  localparam int NCH = (W + CHUNK - 1) / CHUNK;

  logic [NCH-1:0] ch_eq;

  // Split the compare into chunks and AND the partial results
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    localparam int LO = c * CHUNK;
    localparam int HI = ((LO + CHUNK) > W) ? (W - 1) : (LO + CHUNK - 1);
    assign ch_eq[c] = (a[HI:LO] == b[HI:LO]);
  end

  assign eq = &ch_eq;
endmodule

// File: rtl/brfl_tgt.sv
module brfl_tgt #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_inc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target
);
  localparam int EXT = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offs;

  // Word offset: sign-extend, then scale by four bytes
  assign offs   = {{EXT{imm[IMM_W-1]}}, imm, 2'b00};
  assign target = pc_inc + offs;
endmodule

// File: rtl/brfl_pc.sv
module brfl_pc
  import brfl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              STEP     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  pcsel_e          sel,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_plus
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  assign pc_plus = pc + STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else if (sel == PC_BR) begin
      pc <= target;
    end else if (!hold) begin
      pc <= pc_plus;
    end
  end
endmodule

// File: rtl/brfl_ifid.sv
module brfl_ifid
  import brfl_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ifid_op_e        op,
  input  logic [ILEN-1:0] instr_d,
  input  logic [XLEN-1:0] pc_inc_d,
  output logic [ILEN-1:0] instr_q,
  output logic [XLEN-1:0] pc_inc_q,
  output logic            valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q  <= '0;
      pc_inc_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      unique case (op)
        IFID_ZERO: begin
          // All-zero word is the shift-by-zero no-op; invalid blocks writes
          instr_q  <= '0;
          pc_inc_q <= '0;
          valid_q  <= 1'b0;
        end
        IFID_LOAD: begin
          instr_q  <= instr_d;
          pc_inc_q <= pc_inc_d;
          valid_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brfl_top.sv
module brfl_top
  import brfl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              ILEN     = 32,
  parameter int              IMM_W    = 16,
  parameter int              CMP_CH   = 8,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic [ILEN-1:0]  fetch_instr_i,
  input  logic             id_branch_i,
  input  logic [XLEN-1:0]  id_opa_i,
  input  logic [XLEN-1:0]  id_opb_i,
  input  logic [XLEN-1:0]  id_pc_inc_i,
  input  logic [IMM_W-1:0] id_imm_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             pc_sel_o,
  output logic [XLEN-1:0]  pc_target_o,
  output logic             flush_o,
  output logic [ILEN-1:0]  ifid_instr_o,
  output logic [XLEN-1:0]  ifid_pc_inc_o,
  output logic             ifid_valid_o
);
  localparam int INSTR_BYTES = ILEN / 8;

  logic            ops_eq;
  logic            taken;
  logic [XLEN-1:0] pc_plus;
  pcsel_e          sel;
  ifid_op_e        ifid_op;

  brfl_eq #(.W(XLEN), .CHUNK(CMP_CH)) u_eq (
    .a  (id_opa_i),
    .b  (id_opb_i),
    .eq (ops_eq)
  );

  brfl_tgt #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .pc_inc (id_pc_inc_i),
    .imm    (id_imm_i),
    .target (pc_target_o)
  );

  assign taken = id_branch_i & ops_eq;
  assign sel   = taken ? PC_BR : PC_SEQ;

  // Flush overrides hold for the fetch/decode register
  always_comb begin
    if (taken)       ifid_op = IFID_ZERO;
    else if (hold_i) ifid_op = IFID_HOLD;
    else             ifid_op = IFID_LOAD;
  end

  brfl_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(INSTR_BYTES)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold_i),
    .sel     (sel),
    .target  (pc_target_o),
    .pc      (pc_o),
    .pc_plus (pc_plus)
  );

  brfl_ifid #(.ILEN(ILEN), .XLEN(XLEN)) u_ifid (
    .clk      (clk),
    .rst      (rst),
    .op       (ifid_op),
    .instr_d  (fetch_instr_i),
    .pc_inc_d (pc_plus),
    .instr_q  (ifid_instr_o),
    .pc_inc_q (ifid_pc_inc_o),
    .valid_q  (ifid_valid_o)
  );

  assign pc_sel_o = (sel == PC_BR);
  assign flush_o  = taken;
endmodule

// File: rtl/brfl_chk.sv
module brfl_chk #(
  parameter int XLEN = 32,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            hold_i,
  input logic            id_branch_i,
  input logic [XLEN-1:0] id_opa_i,
  input logic [XLEN-1:0] id_opb_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] pc_target_o,
  input logic            pc_sel_o,
  input logic            flush_o,
  input logic [ILEN-1:0] ifid_instr_o,
  input logic            ifid_valid_o
);
  AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> id_branch_i); // R9

  AST_FLUSH_NEEDS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (id_opa_i == id_opb_i)); // R3

  AST_TAKEN_NOP: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (ifid_instr_o == '0) && !ifid_valid_o); // R6

  AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (pc_o == $past(pc_target_o))); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !flush_o) |=> ($stable(pc_o) && $stable(ifid_instr_o))); // R7

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && !pc_sel_o) |=> (pc_o == $past(pc_o) + XLEN'(4))); // R2
endmodule

bind brfl_top brfl_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .hold_i       (hold_i),
  .id_branch_i  (id_branch_i),
  .id_opa_i     (id_opa_i),
  .id_opb_i     (id_opb_i),
  .pc_o         (pc_o),
  .pc_target_o  (pc_target_o),
  .pc_sel_o     (pc_sel_o),
  .flush_o      (flush_o),
  .ifid_instr_o (ifid_instr_o),
  .ifid_valid_o (ifid_valid_o)
);

// File: tb/sim_brfl_top.sv
`timescale 1ns/1ps
module sim_brfl_top;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold_i = 1'b0;
  logic [31:0] fetch_instr_i = '0;
  logic        id_branch_i = 1'b0;
  logic [31:0] id_opa_i = '0, id_opb_i = '0, id_pc_inc_i = '0;
  logic [15:0] id_imm_i = '0;
  logic [31:0] pc_o, pc_target_o, ifid_instr_o, ifid_pc_inc_o;
  logic        pc_sel_o, flush_o, ifid_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CYC/2) clk = ~clk;

  brfl_top u0 (
    .clk(clk), .rst(rst), .hold_i(hold_i), .fetch_instr_i(fetch_instr_i),
    .id_branch_i(id_branch_i), .id_opa_i(id_opa_i), .id_opb_i(id_opb_i),
    .id_pc_inc_i(id_pc_inc_i), .id_imm_i(id_imm_i), .pc_o(pc_o),
    .pc_sel_o(pc_sel_o), .pc_target_o(pc_target_o), .flush_o(flush_o),
    .ifid_instr_o(ifid_instr_o), .ifid_pc_inc_o(ifid_pc_inc_o),
    .ifid_valid_o(ifid_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive just after a falling edge
  task automatic drive(input logic hold, input logic br, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] pinc, input logic [15:0] imm);
    @(negedge clk);
    hold_i = hold; id_branch_i = br; id_opa_i = a; id_opb_i = b;
    id_pc_inc_i = pinc; id_imm_i = imm;
    fetch_instr_i = 32'hC0DE_0000 ^ pc_o;
    #2;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 instr", ifid_instr_o, 32'h0);
    chk("R1 pcinc", ifid_pc_inc_o, 32'h0);
    chk("R1 valid", {31'b0, ifid_valid_o}, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_seq(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] p, w;
      drive(1'b0, 1'b0, 32'h1, 32'h2, 32'h0, 16'h0);
      p = pc_o; w = fetch_instr_i;
      edge_wait();
      chk("R2 pc", pc_o, p + 32'd4);
      chk("R2 instr", ifid_instr_o, w);
      chk("R2 pcinc", ifid_pc_inc_o, p + 32'd4);
      chk("R2 valid", {31'b0, ifid_valid_o}, 32'h1);
    end
  endtask

  task automatic t_cmp();
    // differ in bit 0
    drive(1'b0, 1'b1, 32'h1234_5678, 32'h1234_5679, 32'h100, 16'h1);
    chk("R3 lsb diff", {31'b0, flush_o}, 32'h0);
    chk("R3 lsb diff sel", {31'b0, pc_sel_o}, 32'h0);
    edge_wait();
    // differ in bit 31
    drive(1'b0, 1'b1, 32'h0000_00FF, 32'h8000_00FF, 32'h100, 16'h1);
    chk("R3 msb diff", {31'b0, flush_o}, 32'h0);
    edge_wait();
    // differ in a middle chunk
    drive(1'b0, 1'b1, 32'hAAAA_5555, 32'hAAAB_5555, 32'h100, 16'h1);
    chk("R3 mid diff", {31'b0, flush_o}, 32'h0);
    edge_wait();
    // equal with branch flag low
    drive(1'b0, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h100, 16'h1);
    chk("R9 no flush", {31'b0, flush_o}, 32'h0);
    chk("R9 no sel", {31'b0, pc_sel_o}, 32'h0);
    begin
      logic [31:0] p;
      p = pc_o;
      edge_wait();
      chk("R9 pc seq", pc_o, p + 32'd4);
      chk("R9 valid", {31'b0, ifid_valid_o}, 32'h1);
    end
  endtask

  task automatic t_target();
    drive(1'b1, 1'b0, 32'h1, 32'h2, 32'h0000_1000, 16'h0010);
    chk("R4 pos", pc_target_o, 32'h0000_1040);
    drive(1'b1, 1'b0, 32'h1, 32'h2, 32'h0000_1000, 16'hFFFF);
    chk("R4 neg1", pc_target_o, 32'h0000_0FFC);
    drive(1'b1, 1'b0, 32'h1, 32'h2, 32'h0004_0000, 16'h8000);
    chk("R4 mostneg", pc_target_o, 32'h0002_0000);
    drive(1'b1, 1'b0, 32'h1, 32'h2, 32'hFFFF_FFF0, 16'h0008);
    chk("R4 wrap", pc_target_o, 32'h0000_0010);
    edge_wait();
  endtask

  task automatic t_nottaken();
    logic [31:0] p, w;
    drive(1'b0, 1'b1, 32'h5, 32'h6, 32'h200, 16'h0040);
    p = pc_o; w = fetch_instr_i;
    edge_wait();
    chk("R5 pc", pc_o, p + 32'd4);
    chk("R5 instr", ifid_instr_o, w);
    chk("R5 valid", {31'b0, ifid_valid_o}, 32'h1);
  endtask

  task automatic t_taken();
    logic [31:0] w;
    drive(1'b0, 1'b1, 32'h7777_0000, 32'h7777_0000, 32'h0000_0200, 16'h0040);
    chk("R3 equal flush", {31'b0, flush_o}, 32'h1);
    chk("R3 equal sel", {31'b0, pc_sel_o}, 32'h1);
    chk("R6 target", pc_target_o, 32'h0000_0300);
    edge_wait();
    chk("R6 pc", pc_o, 32'h0000_0300);
    chk("R6 nop", ifid_instr_o, 32'h0);
    chk("R6 invalid", {31'b0, ifid_valid_o}, 32'h0);
    drive(1'b0, 1'b0, 32'h1, 32'h2, 32'h0, 16'h0);
    w = fetch_instr_i;
    edge_wait();
    chk("R6 resume pc", pc_o, 32'h0000_0304);
    chk("R6 resume instr", ifid_instr_o, w);
    chk("R6 resume valid", {31'b0, ifid_valid_o}, 32'h1);
  endtask

  task automatic t_hold();
    logic [31:0] p, w, pi;
    drive(1'b0, 1'b0, 32'h1, 32'h2, 32'h0, 16'h0);
    edge_wait();
    p = pc_o; w = ifid_instr_o; pi = ifid_pc_inc_o;
    for (int i = 0; i < 2; i++) begin
      drive(1'b1, 1'b1, 32'h3, 32'h4, 32'h0, 16'h0);
      edge_wait();
      chk("R7 pc", pc_o, p);
      chk("R7 instr", ifid_instr_o, w);
      chk("R7 pcinc", ifid_pc_inc_o, pi);
      chk("R7 valid", {31'b0, ifid_valid_o}, 32'h1);
    end
  endtask

  task automatic t_hold_flush();
    drive(1'b1, 1'b1, 32'h0BAD_F00D, 32'h0BAD_F00D, 32'h0000_0800, 16'hFFF0);
    edge_wait();
    chk("R8 pc", pc_o, 32'h0000_07C0);
    chk("R8 nop", ifid_instr_o, 32'h0);
    chk("R8 invalid", {31'b0, ifid_valid_o}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CYC * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    t_reset();
    t_seq(4);
    t_cmp();
    t_target();
    t_nottaken();
    t_taken();
    t_hold();
    t_hold_flush();
    t_seq(2);
    drive(1'b0, 1'b0, 32'h1, 32'h2, 32'h0, 16'h0);
    finish_run();
  end
endmodule